// File: doc/BRIEF.md
# Twiddle-Grouped Radix-2 DIF Butterfly Sequencer

This block produces the order in which the butterflies of an in-place N-point radix-2 decimation-in-frequency FFT are issued. It does not run them in plain stage order. It collects butterflies from different stages that share one twiddle factor and issues them together, so the arithmetic unit downstream fetches each distinct twiddle exponent from its coefficient store only once over the whole transform.

A start pulse begins a transform. The block then offers one butterfly descriptor per cycle under a valid/ready handshake. Each descriptor holds:

- the stage number,
- the upper and lower data indices,
- the twiddle exponent,
- a strobe that marks the first use of that exponent.

The issue is split into log2(N) steps. Step j carries every butterfly whose exponent is last used in stage j. The final step carries all W^0 butterflies, in increasing stage order, because those depend on each other across stages. A one-cycle done pulse closes the transform. N is a power-of-two parameter, at least 4.

Top module: `tw_group_seq`

## Requirements
- R1: After reset, `valid_o` and `done_o` are low, and they stay low until a start pulse is seen.
- R2: A `start_i` sampled while idle makes the first descriptor valid on the next cycle. A `start_i` sampled while a transform is in progress has no effect on the sequence.
- R3: One transform issues exactly N/2·log2(N) descriptors. Each (stage, upper) pair of the FFT appears exactly once. In every descriptor, lower = upper + N/2^stage and upper mod 2^(log2(N)−stage+1) < N/2^stage.
- R4: The twiddle exponent equals (upper mod N/2^stage)·2^(stage−1).
- R5: Descriptors are grouped by step. The step of a descriptor is the last stage in which its exponent occurs, and exponent 0 belongs to step log2(N). Steps are issued in increasing order. Within a step, stages are issued in increasing order, and within a stage, upper indices are issued in increasing order.
- R6: `twload_o` is high on exactly the first descriptor of the transform that carries a given exponent, and on no other. That gives N/2 strobes per transform.
- R7: While `valid_o` is high and `ready_i` is low, the descriptor holds all its fields stable.
- R8: `done_o` is high for exactly one cycle, the cycle after the final descriptor is accepted. `valid_o` is low in that cycle.
- R9: `stage_o` is 1-based: 1 is the first stage and log2(N) the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transform when idle |
| ready_i | input | 1 | Consumer accepts the current descriptor |
| valid_o | output | 1 | Descriptor is valid |
| stage_o | output | $clog2(log2(N)+1) | Stage number, 1-based |
| upper_o | output | log2(N) | Upper data index |
| lower_o | output | log2(N) | Lower data index |
| twexp_o | output | log2(N)-1 | Twiddle exponent k of W_N^k |
| twload_o | output | 1 | First use of this exponent |
| done_o | output | 1 | One-cycle end-of-transform pulse |

## Verification
The assertions check local invariants on every cycle:
- descriptor hold under back-pressure;
- the spacing between the lower and upper index for the stage;
- exponent alignment to the stage;
- stage range;
- the done pulse's width, its timing relative to a handshake, and valid being low alongside it;
- the first descriptor opening at stage 1 with a strobe.

Only the bench's scenarios can show the global properties. These are the exact cross-stage step order, each butterfly issued exactly once, each exponent strobed exactly once, and a mid-run start being ignored. The bench sets all of these against a reference sequence that it builds from stage-order FFT enumeration under several ready patterns.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  // butterfly distance in a 1-based stage
  function automatic int span_of(int n, int stage);
    return n >> stage;
  endfunction

  // butterflies per group that a step issues in any of its stages
  function automatic int per_group(int n, int l, int step);
    return (step == l) ? 1 : (n >> (step + 1));
  endfunction

  // offset inside a group for the m-th butterfly of a step/stage
  function automatic int offset_of(int l, int step, int stage, int m);
    return (step == l) ? 0 : ((2 * m + 1) << (step - stage));
  endfunction

  function automatic int upper_of(int n, int stage, int grp, int k);
    return 2 * grp * (n >> stage) + k;
  endfunction

  function automatic int exp_of(int stage, int k);
    return k << (stage - 1);
  endfunction
endpackage

// File: rtl/tgs_walker.sv
module tgs_walker #(
  parameter int N  = 32,
  parameter int L  = $clog2(N),
  parameter int SW = $clog2(L + 1),
  parameter int CW = L
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          adv_i,
  output logic [SW-1:0] step_o,
  output logic [SW-1:0] stage_o,
  output logic [CW-1:0] grp_o,
  output logic [CW-1:0] mi_o,
  output logic          last_o
);
  import tgs_pkg::*;

  logic [SW-1:0] step_q, stage_q;
  logic [CW-1:0] grp_q, mi_q;
  int   glim, mlim;
  logic m_end, g_end, s_end;

  always_comb begin
    glim   = 1 << (int'(stage_q) - 1);
    mlim   = per_group(N, L, int'(step_q));
    m_end  = (int'(mi_q) == mlim - 1);
    g_end  = (int'(grp_q) == glim - 1);
    s_end  = (stage_q == step_q);
    last_o = m_end && g_end && s_end && (step_q == SW'(L));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_i) begin
      step_q  <= SW'(1);
      stage_q <= SW'(1);
      grp_q   <= '0;
      mi_q    <= '0;
    end else if (adv_i) begin
      if (!m_end) begin
        mi_q <= mi_q + CW'(1);
      end else begin
        mi_q <= '0;
        if (!g_end) begin
          grp_q <= grp_q + CW'(1);
        end else begin
          grp_q <= '0;
          if (!s_end) begin
            stage_q <= stage_q + SW'(1);
          end else begin
            stage_q <= SW'(1);
            step_q  <= step_q + SW'(1);
          end
        end
      end
    end
  end

  assign step_o  = step_q;
  assign stage_o = stage_q;
  assign grp_o   = grp_q;
  assign mi_o    = mi_q;
endmodule

// File: rtl/tgs_desc.sv
module tgs_desc #(
  parameter int N  = 32,
  parameter int L  = $clog2(N),
  parameter int SW = $clog2(L + 1),
  parameter int CW = L,
  parameter int AW = L,
  parameter int EW = L - 1
) (
  input  logic [SW-1:0] step_i,
  input  logic [SW-1:0] stage_i,
  input  logic [CW-1:0] grp_i,
  input  logic [CW-1:0] mi_i,
  output logic [AW-1:0] upper_o,
  output logic [AW-1:0] lower_o,
  output logic [EW-1:0] twexp_o,
  output logic          twload_o
);
  import tgs_pkg::*;

  int k, u;

  always_comb begin
    k        = offset_of(L, int'(step_i), int'(stage_i), int'(mi_i));
    u        = upper_of(N, int'(stage_i), int'(grp_i), k);
    upper_o  = AW'(u);
    lower_o  = AW'(u + span_of(N, int'(stage_i)));
    twexp_o  = EW'(exp_of(int'(stage_i), k));
    // every exponent of a step first appears in stage 1
    twload_o = (stage_i == SW'(1));
  end
endmodule

// File: rtl/tgs_ctrl.sv
module tgs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ready_i,
  input  logic last_i,
  output logic init_o,
  output logic fire_o,
  output logic valid_o,
  output logic done_o
);
  logic busy_q, done_q;

  assign init_o  = start_i && !busy_q;
  assign fire_o  = busy_q && ready_i;
  assign valid_o = busy_q;
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_o && last_i;
      if (init_o)
        busy_q <= 1'b1;
      else if (fire_o && last_i)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_group_seq.sv
module tw_group_seq #(
  parameter int N = 32,
  localparam int L  = $clog2(N),
  localparam int SW = $clog2(L + 1),
  localparam int AW = L,
  localparam int EW = L - 1,
  localparam int CW = L
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [SW-1:0] stage_o,
  output logic [AW-1:0] upper_o,
  output logic [AW-1:0] lower_o,
  output logic [EW-1:0] twexp_o,
  output logic          twload_o,
  output logic          done_o
);
  // internal events brought out for the checker
  logic          init_w, fire_w, last_w;
  logic [SW-1:0] step_w;
  logic [CW-1:0] grp_w, mi_w;

  tgs_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
    .last_i(last_w), .init_o(init_w), .fire_o(fire_w),
    .valid_o(valid_o), .done_o(done_o)
  );

  tgs_walker #(.N(N), .L(L), .SW(SW), .CW(CW)) walk_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_w), .adv_i(fire_w),
    .step_o(step_w), .stage_o(stage_o), .grp_o(grp_w), .mi_o(mi_w),
    .last_o(last_w)
  );

  tgs_desc #(.N(N), .L(L), .SW(SW), .CW(CW), .AW(AW), .EW(EW)) desc_i (
    .step_i(step_w), .stage_i(stage_o), .grp_i(grp_w), .mi_i(mi_w),
    .upper_o(upper_o), .lower_o(lower_o), .twexp_o(twexp_o),
    .twload_o(twload_o)
  );
endmodule

// File: rtl/tgs_chk.sv
module tgs_chk #(
  parameter int N = 32,
  localparam int L  = $clog2(N),
  localparam int SW = $clog2(L + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_i,
  input logic          valid_o,
  input logic [SW-1:0] stage_o,
  input logic [L-1:0]  upper_o,
  input logic [L-1:0]  lower_o,
  input logic [L-2:0]  twexp_o,
  input logic          twload_o,
  input logic          done_o,
  input logic          fire_w
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(stage_o) && $stable(upper_o)
      && $stable(lower_o) && $stable(twexp_o) && $stable(twload_o));

  // R3
  pair_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(lower_o) - int'(upper_o)) == (N >> int'(stage_o)));

  // R4
  exp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && twexp_o != '0 |->
      (int'(twexp_o) % (1 << (int'(stage_o) - 1))) == 0);

  // R9
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> int'(stage_o) >= 1 && int'(stage_o) <= L);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fire_w) && !valid_o);

  // R6
  first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> twload_o && stage_o == SW'(1));
endmodule

bind tw_group_seq tgs_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .valid_o(valid_o),
  .stage_o(stage_o), .upper_o(upper_o), .lower_o(lower_o),
  .twexp_o(twexp_o), .twload_o(twload_o), .done_o(done_o), .fire_w(fire_w)
);

// File: tb/tw_group_seq_tb.sv
module tw_group_seq_tb_top;
  localparam int N   = 32;
  localparam int L   = $clog2(N);
  localparam int SW  = $clog2(L + 1);
  localparam int TOT = L * N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ready_i = 1'b0;
  logic valid_o, twload_o, done_o;
  logic [SW-1:0] stage_o;
  logic [L-1:0]  upper_o, lower_o;
  logic [L-2:0]  twexp_o;

  int tests = 0;
  int fails = 0;

  int ex_s[TOT], ex_u[TOT], ex_l[TOT], ex_e[TOT], ex_ld[TOT];

  always #5 clk = ~clk;

  tw_group_seq #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
    .valid_o(valid_o), .stage_o(stage_o), .upper_o(upper_o),
    .lower_o(lower_o), .twexp_o(twexp_o), .twload_o(twload_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // last stage in which exponent e occurs in stage-order DIF
  function automatic int last_stage(int e);
    int lst = 0;
    for (int t = 1; t <= L; t++)
      if ((e % (1 << (t - 1))) == 0 && (e / (1 << (t - 1))) < (N >> t))
        lst = t;
    return lst;
  endfunction

  task automatic build_ref();
    int n = 0;
    bit seen[N/2];
    for (int e = 0; e < N/2; e++) seen[e] = 1'b0;
    for (int st = 1; st <= L; st++)
      for (int s = 1; s <= L; s++)
        for (int u = 0; u < N; u++) begin
          int sp = N >> s;
          if (((u / sp) % 2) == 0) begin
            int k = u % sp;
            int e = k << (s - 1);
            if (last_stage(e) == st) begin
              ex_s[n] = s; ex_u[n] = u; ex_l[n] = u + sp; ex_e[n] = e;
              ex_ld[n] = seen[e] ? 0 : 1;
              seen[e] = 1'b1;
              n++;
            end
          end
        end
    chk(n == TOT, "R3 reference size", n, TOT);
  endtask

  // mode 0: always ready; 1: stalls every third cycle; 2: stalls plus start mid-run
  task automatic run_seq(input int mode);
    int idx = 0;
    int cyc = 0;
    int loads = 0;
    bit stall = 1'b0;
    int h_s = 0, h_u = 0, h_e = 0;
    bit hit[L+1][N];
    for (int s = 0; s <= L; s++)
      for (int u = 0; u < N; u++) hit[s][u] = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (idx < TOT && cyc < 4000) begin
      if (stall) begin
        chk(valid_o && int'(stage_o) == h_s && int'(upper_o) == h_u &&
            int'(twexp_o) == h_e, "R7 hold", int'(upper_o), h_u);
      end
      ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      start_i = (mode == 2 && (cyc == 17 || cyc == 40)) ? 1'b1 : 1'b0;
      if (valid_o && ready_i) begin
        chk(int'(stage_o) == ex_s[idx], "R9 stage", int'(stage_o), ex_s[idx]);
        chk(int'(upper_o) == ex_u[idx], "R5 upper order", int'(upper_o), ex_u[idx]);
        chk(int'(lower_o) == ex_l[idx], "R3 lower", int'(lower_o), ex_l[idx]);
        chk(int'(twexp_o) == ex_e[idx], "R4 exponent", int'(twexp_o), ex_e[idx]);
        chk(int'(twload_o) == ex_ld[idx], "R6 strobe", int'(twload_o), ex_ld[idx]);
        if (hit[stage_o][upper_o])
          chk(1'b0, "R3 duplicate butterfly", int'(upper_o), -1);
        hit[stage_o][upper_o] = 1'b1;
        if (twload_o) loads++;
        idx++;
        stall = 1'b0;
      end else begin
        if (!valid_o) chk(1'b0, "R2 valid during run", 0, 1);
        stall = 1'b1;
        h_s = int'(stage_o); h_u = int'(upper_o); h_e = int'(twexp_o);
      end
      if (idx < TOT) chk(!done_o, "R8 early done", int'(done_o), 0);
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(idx == TOT, "R3 descriptor count", idx, TOT);
    chk(loads == N/2, "R6 strobe count", loads, N/2);
    chk(done_o == 1'b1, "R8 done after last", int'(done_o), 1);
    chk(valid_o == 1'b0, "R8 valid low with done", int'(valid_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    chk(valid_o == 1'b0, "R2 idle after run", int'(valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    build_ref();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ready_i = 1'b1;
    // R1
    chk(valid_o == 1'b0, "R1 valid at reset", int'(valid_o), 0);
    chk(done_o == 1'b0, "R1 done at reset", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk(valid_o == 1'b0, "R1 idle without start", int'(valid_o), 0);
    run_seq(0);
    run_seq(1);
    run_seq(2);
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && done_o == 1'b0, "R1 quiet at end", int'(valid_o), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule